// File: doc/BRIEF.md
# Per-Timeslot Receive Octet Conditioner

This block sits in the receive path of a T1/E1 line, after framing and before the backplane. Every timeslot octet arrives with its timeslot index and a valid strobe. The block looks up a 4-bit conditioning code for that timeslot in a table of per-channel registers and returns the conditioned octet one clock later. The code can leave the octet alone, invert some of its bits, or replace it with a pattern. The replacement patterns are vacant, busy, a fixed idle octet, an A-law or µ-law milliwatt tone, and a pseudo-random sequence. The last code marks the timeslot as carrying data-link traffic.

The table is loaded through a simple write port, one channel per write. A frame-start pulse moves the milliwatt tone forward through its cycle once per frame. One select input chooses which pseudo-random source feeds the substitution code.

Top module: `rx_octet_cond`

## Requirements
- R1: After reset every channel code is 0. The outputs `out_valid`, `out_de` and `out_octet` are 0. The first octets after reset come out unchanged.
- R2: An octet that is presented with `in_valid` high appears on `out_octet` one clock later, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low, `out_de` low and `out_octet` 0 one clock later. A code write takes effect from the next cycle on. An octet that arrives in the same cycle as a write to its own channel uses the code the channel held before the write.
- R3: Codes 0x0 to 0x5 and 0xE pass the octet through unchanged, with `out_de` low.
- R4: Code 0x6 replaces the octet with 0xFF. Code 0x8 replaces it with 0x1A.
- R5: Code 0x7 replaces the octet with a busy octet: bits 7:5 are 111, and bits 4:0 hold the timeslot index.
- R6: Code 0xB inverts bit 7 only. Code 0xC inverts bits 6:0 and leaves bit 7 as it is.
- R7: A frame phase counter sets the milliwatt step.
  - The counter resets to 7 and goes up by one, modulo 8, on each `frame_start`.
  - An octet presented together with `frame_start` already uses the incremented value.
  - Code 0x9 outputs the A-law step for that phase: 34 21 21 34 B4 A1 A1 B4 (hex), for phases 0 to 7.
  - Code 0xA outputs the µ-law step: 1E 0B 0B 1E 9E 8B 8B 9E (hex).
- R8: Code 0xD with `prbs_type`=0 outputs the next 8 bits of a 15-bit LFSR.
  - The LFSR is seeded with all ones at reset.
  - Each step takes fb = s[14]^s[13], shifts fb in at bit 0, and outputs fb.
  - The first bit of each group of 8 goes to octet bit 7.
  - The LFSR advances by 8 steps only when an octet is substituted.
- R9: Code 0xD with `prbs_type`=1 outputs the next 8 bits of a 20-bit LFSR.
  - The LFSR is seeded with all ones at reset.
  - Each step takes fb = s[19]^s[16], shifts fb in at bit 0, and outputs the bit fb.
  - A bit that follows 14 output zeros is forced to 1.
  - This LFSR advances only when it is the selected source.
- R10: Code 0xF passes the octet unchanged and raises `out_de` alongside it.
- R11: A timeslot index of NUM_CH or more passes its octet unchanged with `out_de` low. A write to such an address changes no channel.

Ports (defaults NUM_CH=24, TS_W=5):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Octet strobe |
| in_ts | input | TS_W | Timeslot index of the octet |
| in_octet | input | 8 | Received octet |
| frame_start | input | 1 | Start of a new frame; advances the milliwatt phase |
| wr_en | input | 1 | Code write strobe |
| wr_addr | input | TS_W | Channel to write |
| wr_code | input | 4 | Conditioning code to store |
| prbs_type | input | 1 | 0: 15-bit PRBS, 1: QRTS source for code 0xD |
| out_valid | output | 1 | Conditioned octet strobe |
| out_octet | output | 8 | Conditioned octet |
| out_de | output | 1 | Marks a data-link timeslot |

## Verification
Two things can happen in one cycle: a code write and an octet on the very channel being written. The bench provokes this both in a directed case and through random writes that land on the active timeslot, and the output must reflect the old code. A frame-start pulse can also coincide with a milliwatt octet; that octet must use the new phase. A bench model judges every cycle. It keeps its own code table, phase counter and both pattern generators, updated in the same read-then-write order the requirements give.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    localparam int OCTET_W = 8;
    localparam int PHASE_W = 3;

    typedef enum logic [3:0] {
        COND_PASS0    = 4'h0,
        COND_PASS1    = 4'h1,
        COND_PASS2    = 4'h2,
        COND_PASS3    = 4'h3,
        COND_PASS4    = 4'h4,
        COND_PASS5    = 4'h5,
        COND_VACANT   = 4'h6,
        COND_BUSY     = 4'h7,
        COND_IDLE1A   = 4'h8,
        COND_MW_ALAW  = 4'h9,
        COND_MW_ULAW  = 4'hA,
        COND_FLIP_MSB = 4'hB,
        COND_FLIP_LOW = 4'hC,
        COND_PRBS     = 4'hD,
        COND_CLEAR    = 4'hE,
        COND_DLINK    = 4'hF
    } cond_e;

    typedef struct packed {
        logic               valid;
        logic               de;
        logic [OCTET_W-1:0] octet;
    } cond_out_t;

    function automatic logic [OCTET_W-1:0] mw_alaw(input logic [PHASE_W-1:0] ph);
        case (ph)
            3'd0, 3'd3: mw_alaw = 8'h34;
            3'd1, 3'd2: mw_alaw = 8'h21;
            3'd4, 3'd7: mw_alaw = 8'hB4;
            default:    mw_alaw = 8'hA1;
        endcase
    endfunction

    function automatic logic [OCTET_W-1:0] mw_ulaw(input logic [PHASE_W-1:0] ph);
        case (ph)
            3'd0, 3'd3: mw_ulaw = 8'h1E;
            3'd1, 3'd2: mw_ulaw = 8'h0B;
            3'd4, 3'd7: mw_ulaw = 8'h9E;
            default:    mw_ulaw = 8'h8B;
        endcase
    endfunction

endpackage

// File: rtl/rxc_code_table.sv
module rxc_code_table
    import rxc_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int TS_W   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [TS_W-1:0] wr_addr,
    input  cond_e           wr_code,
    input  logic [TS_W-1:0] rd_ts,
    output cond_e           rd_code,
    output logic            rd_in_range
);
    localparam int SLOTS = 2 ** TS_W;

    cond_e tbl [SLOTS];

    for (genvar ch = 0; ch < SLOTS; ch++) begin : g_slot
        if (ch < NUM_CH) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    tbl[ch] <= COND_PASS0;
                end else if (wr_en && wr_addr == TS_W'(ch)) begin
                    tbl[ch] <= wr_code;
                end
            end
        end else begin : g_none
            assign tbl[ch] = COND_PASS0;
        end
    end

    assign rd_in_range = (32'(rd_ts) < NUM_CH);
    assign rd_code     = rd_in_range ? tbl[rd_ts] : COND_PASS0;

endmodule

// File: rtl/rxc_pattern_gen.sv
module rxc_pattern_gen
    import rxc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               advance,
    input  logic               prbs_type,
    output logic [PHASE_W-1:0] phase,
    output logic [OCTET_W-1:0] prbs_octet
);
    localparam int ZRUN_LIMIT = 14;

    logic [PHASE_W-1:0] phase_q;
    logic [14:0]        l15_q, l15_n;
    logic [19:0]        l20_q, l20_n;
    logic [3:0]         zrun_q, zrun_n;

    assign phase = frame_start ? phase_q + 1'b1 : phase_q;

    always_comb begin
        logic fb;
        logic bit_out;
        l15_n      = l15_q;
        l20_n      = l20_q;
        zrun_n     = zrun_q;
        prbs_octet = '0;
        for (int i = 0; i < OCTET_W; i++) begin
            if (!prbs_type) begin
                fb      = l15_n[14] ^ l15_n[13];
                l15_n   = {l15_n[13:0], fb};
                bit_out = fb;
            end else begin
                fb      = l20_n[19] ^ l20_n[16];
                l20_n   = {l20_n[18:0], fb};
                bit_out = fb | (32'(zrun_n) >= ZRUN_LIMIT);
                zrun_n  = bit_out ? 4'd0 : zrun_n + 4'd1;
            end
            prbs_octet[OCTET_W-1-i] = bit_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '1;
            l15_q   <= '1;
            l20_q   <= '1;
            zrun_q  <= '0;
        end else begin
            phase_q <= phase;
            if (advance) begin
                l15_q  <= l15_n;
                l20_q  <= l20_n;
                zrun_q <= zrun_n;
            end
        end
    end

endmodule

// File: rtl/rxc_cond_mux.sv
module rxc_cond_mux
    import rxc_pkg::*;
#(
    parameter int TS_W = 5
) (
    input  logic               valid,
    input  cond_e              code,
    input  logic [TS_W-1:0]    ts,
    input  logic [OCTET_W-1:0] octet,
    input  logic [PHASE_W-1:0] phase,
    input  logic [OCTET_W-1:0] prbs_octet,
    output cond_out_t          res
);
    always_comb begin
        res.valid = valid;
        res.de    = 1'b0;
        res.octet = octet;
        case (code)
            COND_VACANT:   res.octet = 8'hFF;
            COND_BUSY:     res.octet = {3'b111, 5'(ts)};
            COND_IDLE1A:   res.octet = 8'h1A;
            COND_MW_ALAW:  res.octet = mw_alaw(phase);
            COND_MW_ULAW:  res.octet = mw_ulaw(phase);
            COND_FLIP_MSB: res.octet = octet ^ 8'h80;
            COND_FLIP_LOW: res.octet = octet ^ 8'h7F;
            COND_PRBS:     res.octet = prbs_octet;
            COND_DLINK:    res.de    = 1'b1;
            default:       res.octet = octet;
        endcase
    end

endmodule

// File: rtl/rx_octet_cond.sv
module rx_octet_cond
    import rxc_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int TS_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [TS_W-1:0] in_ts,
    input  logic [7:0]      in_octet,
    input  logic            frame_start,
    input  logic            wr_en,
    input  logic [TS_W-1:0] wr_addr,
    input  logic [3:0]      wr_code,
    input  logic            prbs_type,
    output logic            out_valid,
    output logic [7:0]      out_octet,
    output logic            out_de
);
    cond_e              cur_code;
    logic               in_range;
    logic [PHASE_W-1:0] phase;
    logic [OCTET_W-1:0] prbs_octet;
    logic               prbs_adv;
    cond_out_t          mux_res;
    cond_out_t          out_q;

    rxc_code_table #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_code    (cond_e'(wr_code)),
        .rd_ts      (in_ts),
        .rd_code    (cur_code),
        .rd_in_range(in_range)
    );

    assign prbs_adv = in_valid && in_range && (cur_code == COND_PRBS);

    rxc_pattern_gen u_pat (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .advance    (prbs_adv),
        .prbs_type  (prbs_type),
        .phase      (phase),
        .prbs_octet (prbs_octet)
    );

    rxc_cond_mux #(.TS_W(TS_W)) u_mux (
        .valid     (in_valid),
        .code      (cur_code),
        .ts        (in_ts),
        .octet     (in_octet),
        .phase     (phase),
        .prbs_octet(prbs_octet),
        .res       (mux_res)
    );

    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            out_q <= '0;
        end else begin
            out_q <= mux_res;
        end
    end

    assign out_valid = out_q.valid;
    assign out_octet = out_q.octet;
    assign out_de    = out_q.de;

endmodule

// File: rtl/rx_octet_cond_chk.sv
module rx_octet_cond_chk #(
    parameter int TS_W = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [TS_W-1:0] in_ts,
    input logic [7:0]      in_octet,
    input logic [3:0]      cur_code,
    input logic            out_valid,
    input logic [7:0]      out_octet,
    input logic            out_de
);
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_de && out_octet == 8'h00));
    p_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (cur_code <= 4'h5 || cur_code == 4'hE))
        |=> (out_octet == $past(in_octet) && !out_de));
    p_vacant_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_code == 4'h6) |=> (out_octet == 8'hFF));
    p_idle1a_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_code == 4'h8) |=> (out_octet == 8'h1A));
    p_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_code == 4'h7)
        |=> (out_octet == {3'b111, 5'($past(in_ts))}));
    p_flip_msb_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_code == 4'hB) |=> (out_octet == ($past(in_octet) ^ 8'h80)));
    p_flip_low_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_code == 4'hC) |=> (out_octet == ($past(in_octet) ^ 8'h7F)));
    p_dlink_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_code == 4'hF) |=> (out_de && out_octet == $past(in_octet)));
    p_de_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
        out_de |-> out_valid);

endmodule

bind rx_octet_cond rx_octet_cond_chk #(.TS_W(TS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ts    (in_ts),
    .in_octet (in_octet),
    .cur_code (cur_code),
    .out_valid(out_valid),
    .out_octet(out_octet),
    .out_de   (out_de)
);

// File: tb/rx_octet_cond_bench.sv
`timescale 1ns/1ps
module rx_octet_cond_bench;
    localparam int NCH = 24;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, frame_start, wr_en, prbs_type;
    logic [4:0] in_ts, wr_addr;
    logic [7:0] in_octet;
    logic [3:0] wr_code;
    logic       out_valid, out_de;
    logic [7:0] out_octet;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [3:0]  m_tbl [NCH];
    logic [2:0]  m_phase;
    logic [14:0] m_l15;
    logic [19:0] m_l20;
    int          m_zrun;

    always #5 clk = ~clk;

    rx_octet_cond #(.NUM_CH(NCH)) u_rx_octet_cond (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ts(in_ts),
        .in_octet(in_octet), .frame_start(frame_start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_code(wr_code), .prbs_type(prbs_type),
        .out_valid(out_valid), .out_octet(out_octet), .out_de(out_de)
    );

    function automatic logic [7:0] alaw_step(input logic [2:0] p);
        logic [7:0] t [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};
        return t[p];
    endfunction

    function automatic logic [7:0] ulaw_step(input logic [2:0] p);
        logic [7:0] t [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};
        return t[p];
    endfunction

    function automatic string req_of(input logic [3:0] c, input bit oor);
        if (oor) return "R11";
        case (c)
            4'h6, 4'h8: return "R4";
            4'h7:       return "R5";
            4'hB, 4'hC: return "R6";
            4'h9, 4'hA: return "R7";
            4'hD:       return prbs_type ? "R9" : "R8";
            4'hF:       return "R10";
            default:    return "R3";
        endcase
    endfunction

    task automatic model_prbs(input logic pt, output logic [7:0] o);
        for (int i = 0; i < 8; i++) begin
            logic b;
            if (!pt) begin
                b     = m_l15[14] ^ m_l15[13];
                m_l15 = {m_l15[13:0], b};
            end else begin
                b     = m_l20[19] ^ m_l20[16];
                m_l20 = {m_l20[18:0], b};
                if (m_zrun >= 14) b = 1'b1;
                m_zrun = b ? 0 : m_zrun + 1;
            end
            o[7-i] = b;
        end
    endtask

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {valid,de,octet} actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic [4:0] ts, input logic [7:0] oct,
                       input logic fs, input logic we, input logic [4:0] wa,
                       input logic [3:0] wc, input logic pt, input string tag);
        logic [3:0] c;
        logic [7:0] e;
        logic       de;
        bit         oor;
        string      req;
        @(negedge clk);
        in_valid = v; in_ts = ts; in_octet = oct; frame_start = fs;
        wr_en = we; wr_addr = wa; wr_code = wc; prbs_type = pt;
        if (fs) m_phase = m_phase + 3'd1;
        oor = (ts >= NCH);
        c   = oor ? 4'h0 : m_tbl[ts];
        e   = oct;
        de  = 1'b0;
        case (c)
            4'h6: e = 8'hFF;
            4'h7: e = {3'b111, ts};
            4'h8: e = 8'h1A;
            4'h9: e = alaw_step(m_phase);
            4'hA: e = ulaw_step(m_phase);
            4'hB: e = oct ^ 8'h80;
            4'hC: e = oct ^ 8'h7F;
            4'hD: if (v) model_prbs(pt, e);
            4'hF: de = 1'b1;
            default: ;
        endcase
        req = (tag != "") ? tag : req_of(c, oor);
        if (we && wa < NCH) m_tbl[wa] = wc;
        @(posedge clk);
        #1;
        if (v) check(req, {out_valid, out_de, out_octet}, {1'b1, de, e});
        else   check("R2", {out_valid, out_de, out_octet}, 10'h000);
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] c);
        cyc(1'b0, 5'd0, 8'h00, 1'b0, 1'b1, a, c, prbs_type, "");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_ts = 0; in_octet = 0; frame_start = 0;
        wr_en = 0; wr_addr = 0; wr_code = 0; prbs_type = 0;
        for (int i = 0; i < NCH; i++) m_tbl[i] = 4'h0;
        m_phase = 3'd7; m_l15 = '1; m_l20 = '1; m_zrun = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", {out_valid, out_de, out_octet}, 10'h000);
        @(negedge clk);
        rst = 1'b0;
        // R1: untouched channels pass after reset
        cyc(1, 5'd3, 8'h5C, 0, 0, 0, 0, 0, "R1");
        cyc(1, 5'd23, 8'hA7, 0, 0, 0, 0, 0, "R1");
        cyc(0, 5'd3, 8'h5C, 0, 0, 0, 0, 0, "");
        // directed codes
        for (int c = 0; c < 16; c++) wr(5'(c), 4'(c));
        for (int c = 0; c < 16; c++) cyc(1, 5'(c), 8'h96, 0, 0, 0, 0, 0, "");
        cyc(1, 5'd7, 8'h00, 0, 0, 0, 0, 0, "R5");
        wr(5'd21, 4'h7);
        cyc(1, 5'd21, 8'h00, 0, 0, 0, 0, 0, "R5");
        // R2: same-cycle write and octet on one channel uses old code
        cyc(1, 5'd4, 8'h3C, 0, 1, 5'd4, 4'h6, 0, "R2");
        cyc(1, 5'd4, 8'h3C, 0, 0, 0, 0, 0, "R2");
        // R7: milliwatt steps across frames, frame_start with the octet
        for (int f = 0; f < 10; f++) begin
            cyc(1, 5'd9, 8'h11, 1, 0, 0, 0, 0, "R7");
            cyc(1, 5'd10, 8'h11, 0, 0, 0, 0, 0, "R7");
        end
        // R8 / R9: PRBS sources
        for (int i = 0; i < 6; i++) cyc(1, 5'd13, 8'h00, 0, 0, 0, 0, 0, "R8");
        for (int i = 0; i < 6; i++) cyc(1, 5'd13, 8'h00, 0, 0, 0, 0, 1, "R9");
        for (int i = 0; i < 3; i++) cyc(1, 5'd13, 8'h00, 0, 0, 0, 0, 0, "R8");
        // R11: out-of-range octet and write
        wr(5'd27, 4'h6);
        cyc(1, 5'd27, 8'h42, 0, 0, 0, 0, 0, "R11");
        wr(5'd24, 4'h6);
        cyc(1, 5'd0, 8'h42, 0, 0, 0, 0, 0, "R11");
        cyc(1, 5'd8, 8'h42, 0, 0, 0, 0, 0, "R11");
        // constrained random
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] ts;
            logic       we;
            logic       pt;
            ts = 5'($urandom_range(0, 31));
            we = ($urandom_range(0, 7) == 0);
            pt = (n / 500) % 2 == 1;
            cyc(($urandom_range(0, 9) != 0), ts, 8'($urandom),
                ($urandom_range(0, 23) == 0), we,
                we && $urandom_range(0, 1) == 1 ? ts : 5'($urandom_range(0, 31)),
                4'($urandom), pt, "");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule